// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Processor Core

This block is a small multi-cycle processor with an 8-bit accumulator, two 8-bit index registers, an 8-bit stack pointer, a 16-bit program counter and four condition flags (negative, overflow, zero, carry). It runs a fixed subset of a classic 8-bit instruction encoding over a 16-bit address bus. The subset covers loads, stores, register and memory increments and decrements, a rotate, an unsigned compare, subtract with borrow, three conditional relative branches, an absolute jump, and subroutine call and return through a stack in page 0x01.

The core talks to one synchronous memory. In each cycle it presents an address and, when it writes, data with a write strobe. The memory returns the byte at the address one cycle later. After reset the core reads a 16-bit start address from a fixed vector and then loops through three steps: fetch an opcode, fetch any operand bytes, and execute. A byte outside the supported subset stops the core. The core then raises a halt output and holds the trapping opcode and its address until the next reset.

Several registers are brought out as read-only observation ports. A simulation environment or a debug probe can use them to follow the architectural state.

Top module: `tiny8_core`

## Requirements
- R1: While `rst` is high the core holds A=0x00, X=0x00, Y=0x00, SP=0xFF, flags=0 and `memWe`=0. In the first cycle after release it drives address 0xFFFC. In the next cycle it drives 0xFFFD. The first opcode fetch comes in the fourth cycle after release, at the address {byte at 0xFFFD, byte at 0xFFFC}.
- R2: `memRdata` is taken as the byte at the address driven one cycle earlier. A write happens in the cycle in which `memWe` is high. `opFetch` is high for exactly one cycle per executed instruction, never in two cycles in a row, and never together with `memWe`.
- R3: The supported loads, stores and increments are: 0xA9 (load A, immediate), 0xA5 (load A, zero page), 0xA4 (load Y, zero page), 0x86 (store X, zero page), 0x8E (store X, absolute, low address byte first), 0xCA (X-1), 0x88 (Y-1), 0xC8 (Y+1), 0xE6 (zero-page byte +1, written back) and 0xEA (no operation). Every load, register step and memory increment sets N to bit 7 of the new value and sets Z when the new value is zero.
- R4: The flags port is {N,V,Z,C} in bits 3..0. Opcode 0xE9 (subtract, immediate) forms A − operand − (1 when C=0, else 0) and writes the low 8 bits to A. It sets C when no borrow occurred. It sets V when A and the operand differ in bit 7 and A and the result also differ in bit 7. It sets N and Z from the result.
- R5: Opcode 0xE0 (compare X, immediate) sets C when X ≥ operand (unsigned) and sets N and Z from the 8-bit value X − operand. X and V are unchanged.
- R6: Opcode 0x2A rotates A left through carry. The old C enters bit 0, the old bit 7 goes to C, and N and Z follow the new A.
- R7: Opcodes 0xD0 (taken when Z=0), 0x90 (taken when C=0) and 0xB0 (taken when C=1) read a signed offset. When taken, the offset is added to the address of the byte that follows the offset. When not taken, execution continues at that byte.
- R8: Opcode 0x4C jumps to the absolute address that follows it. Opcode 0x9A copies X to SP. Opcode 0x20 writes the high byte and then the low byte of (address of the call's last byte) to page 0x01 at SP, decrementing SP after each write, and then jumps. Opcode 0x60 reads the two bytes back from SP+1 and SP+2, leaves SP two higher, and resumes at the restored address + 1.
- R9: Any opcode not listed in R3 to R8 raises `halted`. `trapOpcode` then holds that byte and `trapPc` holds its address.
- R10: Once halted, the core stays halted until reset, never asserts `memWe`, and keeps `regPc`, `trapPc` and `trapOpcode` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Memory address for this cycle |
| memWdata | output | 8 | Write data, valid while memWe is high |
| memWe | output | 1 | Write strobe |
| memRdata | input | 8 | Byte at the address driven in the previous cycle |
| opFetch | output | 1 | High in an opcode fetch cycle |
| halted | output | 1 | Core stopped on an unsupported opcode |
| trapOpcode | output | 8 | Unsupported opcode seen (0 when not halted) |
| trapPc | output | 16 | Address of that opcode (0 when not halted) |
| regA | output | 8 | Accumulator |
| regX | output | 8 | X index register |
| regY | output | 8 | Y index register |
| regSp | output | 8 | Stack pointer (low byte inside page 0x01) |
| regPc | output | 16 | Program counter |
| flags | output | 4 | {N,V,Z,C} |

## Verification
The assertions check the bus-level rules on every cycle. They check that opcode fetches are single cycles with no write, that the halt state is sticky and never writes, and that the frozen program counter and trap values stay put while halted. The instruction results can only be shown by the bench's directed programs. These results are the flag values of subtract and compare at their borrow and overflow corners, the rotate through carry, the branch targets, and the stack bytes written by a call. The nested countdown loop ties the fetch count to a number of executed instructions worked out by hand.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam logic [7:0] OP_LOAD_A_IMM  = 8'hA9;
  localparam logic [7:0] OP_LOAD_A_ZP   = 8'hA5;
  localparam logic [7:0] OP_LOAD_Y_ZP   = 8'hA4;
  localparam logic [7:0] OP_STORE_X_ZP  = 8'h86;
  localparam logic [7:0] OP_STORE_X_ABS = 8'h8E;
  localparam logic [7:0] OP_DEC_X       = 8'hCA;
  localparam logic [7:0] OP_DEC_Y       = 8'h88;
  localparam logic [7:0] OP_INC_Y       = 8'hC8;
  localparam logic [7:0] OP_INC_ZP      = 8'hE6;
  localparam logic [7:0] OP_ROTL_A      = 8'h2A;
  localparam logic [7:0] OP_BR_NZ       = 8'hD0;
  localparam logic [7:0] OP_BR_NC       = 8'h90;
  localparam logic [7:0] OP_BR_C        = 8'hB0;
  localparam logic [7:0] OP_JUMP        = 8'h4C;
  localparam logic [7:0] OP_CALL        = 8'h20;
  localparam logic [7:0] OP_RET         = 8'h60;
  localparam logic [7:0] OP_X_TO_SP     = 8'h9A;
  localparam logic [7:0] OP_CMP_X_IMM   = 8'hE0;
  localparam logic [7:0] OP_SUB_IMM     = 8'hE9;
  localparam logic [7:0] OP_NOP         = 8'hEA;

  typedef enum logic [3:0] {
    K_IMPL, K_IMM, K_ZP_RD, K_ZP_WR, K_ABS_WR,
    K_JUMP, K_CALL, K_RET, K_BRANCH, K_ILLEGAL
  } kind_e;

  typedef enum logic [2:0] {
    A_PC, A_VEC_LO, A_VEC_HI, A_ZP_NOW, A_ZP_LO, A_ABS, A_PUSH, A_POP
  } addr_sel_e;

  typedef enum logic [1:0] {W_X, W_INC, W_RET_HI, W_RET_LO} wdat_sel_e;

  typedef enum logic [2:0] {
    P_HOLD, P_INC, P_LOAD_RD, P_LOAD_HL, P_BRANCH, P_RETURN
  } pc_sel_e;

  typedef struct packed {
    addr_sel_e addrSel;
    wdat_sel_e wdSel;
    pc_sel_e   pcSel;
    logic      memWe;
    logic      loadLo;
    logic      loadHi;
    logic      spUp;
    logic      spDown;
    logic      exec;
  } strobe_t;

  function automatic kind_e kindOf(input logic [7:0] op);
    case (op)
      OP_DEC_X, OP_DEC_Y, OP_INC_Y, OP_ROTL_A, OP_X_TO_SP, OP_NOP: kindOf = K_IMPL;
      OP_LOAD_A_IMM, OP_CMP_X_IMM, OP_SUB_IMM:                    kindOf = K_IMM;
      OP_LOAD_A_ZP, OP_LOAD_Y_ZP, OP_INC_ZP:                      kindOf = K_ZP_RD;
      OP_STORE_X_ZP:                                              kindOf = K_ZP_WR;
      OP_STORE_X_ABS:                                             kindOf = K_ABS_WR;
      OP_JUMP:                                                    kindOf = K_JUMP;
      OP_CALL:                                                    kindOf = K_CALL;
      OP_RET:                                                     kindOf = K_RET;
      OP_BR_NZ, OP_BR_NC, OP_BR_C:                                kindOf = K_BRANCH;
      default:                                                    kindOf = K_ILLEGAL;
    endcase
  endfunction

endpackage

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
  import tiny8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] memRdata,
  output strobe_t    strb,
  output logic [7:0] curOp,
  output logic       opFetch,
  output logic       halted,
  output logic [7:0] trapOpcode
);

  typedef enum logic [3:0] {
    S_VEC0, S_VEC1, S_VEC2, S_FETCH, S_DECODE, S_OPER1, S_OPER2,
    S_MEM, S_PUSH, S_POP1, S_POP2, S_HALT
  } state_e;

  state_e     state, nextState;
  logic [7:0] opReg;
  kind_e      kind;

  // In the decode cycle the opcode is still on the read bus.
  assign curOp = (state == S_DECODE) ? memRdata : opReg;
  assign kind  = kindOf(curOp);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_VEC0;
      opReg <= 8'h00;
    end else begin
      state <= nextState;
      if (state == S_DECODE) opReg <= memRdata;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_VEC0: begin strb.addrSel = A_VEC_LO; nextState = S_VEC1; end
      S_VEC1: begin strb.addrSel = A_VEC_HI; strb.loadLo = 1'b1; nextState = S_VEC2; end
      S_VEC2: begin strb.pcSel = P_LOAD_RD; nextState = S_FETCH; end
      S_FETCH: begin strb.addrSel = A_PC; strb.pcSel = P_INC; nextState = S_DECODE; end
      S_DECODE: begin
        case (kind)
          K_ILLEGAL: nextState = S_HALT;
          K_IMPL:    begin strb.exec = 1'b1; nextState = S_FETCH; end
          K_RET:     begin strb.addrSel = A_POP; strb.spUp = 1'b1; nextState = S_POP1; end
          default:   begin strb.addrSel = A_PC; strb.pcSel = P_INC; nextState = S_OPER1; end
        endcase
      end
      S_OPER1: begin
        strb.loadLo = 1'b1;
        nextState   = S_FETCH;
        case (kind)
          K_IMM:    strb.exec  = 1'b1;
          K_BRANCH: strb.pcSel = P_BRANCH;
          K_ZP_RD:  begin strb.addrSel = A_ZP_NOW; nextState = S_MEM; end
          K_ZP_WR:  begin strb.addrSel = A_ZP_NOW; strb.memWe = 1'b1; strb.wdSel = W_X; end
          default:  begin strb.addrSel = A_PC; strb.pcSel = P_INC; nextState = S_OPER2; end
        endcase
      end
      S_OPER2: begin
        strb.loadHi = 1'b1;
        nextState   = S_FETCH;
        case (kind)
          K_ABS_WR: begin strb.addrSel = A_ABS; strb.memWe = 1'b1; strb.wdSel = W_X; end
          K_JUMP:   strb.pcSel = P_LOAD_RD;
          default: begin
            strb.addrSel = A_PUSH; strb.memWe = 1'b1; strb.wdSel = W_RET_HI;
            strb.spDown  = 1'b1;   nextState  = S_PUSH;
          end
        endcase
      end
      S_MEM: begin
        strb.exec = 1'b1;
        nextState = S_FETCH;
        if (curOp == OP_INC_ZP) begin
          strb.addrSel = A_ZP_LO; strb.memWe = 1'b1; strb.wdSel = W_INC;
        end
      end
      S_PUSH: begin
        strb.addrSel = A_PUSH; strb.memWe = 1'b1; strb.wdSel = W_RET_LO;
        strb.spDown  = 1'b1;   strb.pcSel = P_LOAD_HL; nextState = S_FETCH;
      end
      S_POP1: begin
        strb.loadLo = 1'b1; strb.addrSel = A_POP; strb.spUp = 1'b1; nextState = S_POP2;
      end
      S_POP2: begin strb.pcSel = P_RETURN; nextState = S_FETCH; end
      S_HALT: nextState = S_HALT;
      default: nextState = S_HALT;
    endcase
  end

  assign opFetch    = (state == S_FETCH);
  assign halted     = (state == S_HALT);
  assign trapOpcode = halted ? opReg : 8'h00;

endmodule

// File: rtl/tiny8_dpath.sv
module tiny8_dpath
  import tiny8_pkg::*;
#(
  parameter logic [15:0] VEC_ADDR   = 16'hFFFC,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  strobe_t     strb,
  input  logic [7:0]  curOp,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memWe,
  output logic [7:0]  regA,
  output logic [7:0]  regX,
  output logic [7:0]  regY,
  output logic [7:0]  regSp,
  output logic [15:0] regPc,
  output logic [3:0]  flags
);

  localparam logic [15:0] VEC_HI_ADDR = VEC_ADDR + 16'd1;

  logic [7:0]  accA, idxX, idxY, sp, lo, hi;
  logic [15:0] pc, retAddr;
  logic        fN, fV, fZ, fC;

  logic [7:0]  aNext, xNext, yNext, spExec, nzVal;
  logic        cNext, vNext, nzUpd, brTaken;
  logic [8:0]  subWide, cmpWide;

  assign retAddr = pc - 16'd1;

  always_comb begin
    case (strb.addrSel)
      A_VEC_LO: memAddr = VEC_ADDR;
      A_VEC_HI: memAddr = VEC_HI_ADDR;
      A_ZP_NOW: memAddr = {8'h00, memRdata};
      A_ZP_LO:  memAddr = {8'h00, lo};
      A_ABS:    memAddr = {memRdata, lo};
      A_PUSH:   memAddr = {STACK_PAGE, sp};
      A_POP:    memAddr = {STACK_PAGE, sp + 8'd1};
      default:  memAddr = pc;
    endcase
    case (strb.wdSel)
      W_INC:    memWdata = memRdata + 8'd1;
      W_RET_HI: memWdata = retAddr[15:8];
      W_RET_LO: memWdata = retAddr[7:0];
      default:  memWdata = idxX;
    endcase
  end
  assign memWe = strb.memWe;

  // Execute stage: the operand, immediate or memory, is always on memRdata.
  always_comb begin
    aNext   = accA;  xNext = idxX;  yNext = idxY;  spExec = sp;
    cNext   = fC;    vNext = fV;    nzVal  = 8'h00; nzUpd = 1'b0;
    subWide = {1'b0, accA} - {1'b0, memRdata} - {8'h00, ~fC};
    cmpWide = {1'b0, idxX} - {1'b0, memRdata};
    case (curOp)
      OP_LOAD_A_IMM, OP_LOAD_A_ZP: begin aNext = memRdata; nzVal = memRdata; nzUpd = 1'b1; end
      OP_LOAD_Y_ZP: begin yNext = memRdata;        nzVal = memRdata; nzUpd = 1'b1; end
      OP_INC_ZP:    begin nzVal = memRdata + 8'd1; nzUpd = 1'b1; end
      OP_DEC_X:     begin xNext = idxX - 8'd1;     nzVal = idxX - 8'd1; nzUpd = 1'b1; end
      OP_DEC_Y:     begin yNext = idxY - 8'd1;     nzVal = idxY - 8'd1; nzUpd = 1'b1; end
      OP_INC_Y:     begin yNext = idxY + 8'd1;     nzVal = idxY + 8'd1; nzUpd = 1'b1; end
      OP_ROTL_A: begin
        aNext = {accA[6:0], fC}; cNext = accA[7];
        nzVal = {accA[6:0], fC}; nzUpd = 1'b1;
      end
      OP_X_TO_SP:   spExec = idxX;
      OP_CMP_X_IMM: begin cNext = ~cmpWide[8]; nzVal = cmpWide[7:0]; nzUpd = 1'b1; end
      OP_SUB_IMM: begin
        aNext = subWide[7:0];
        cNext = ~subWide[8];
        vNext = (accA[7] ^ memRdata[7]) & (accA[7] ^ subWide[7]);
        nzVal = subWide[7:0]; nzUpd = 1'b1;
      end
      default: ;
    endcase
    case (curOp)
      OP_BR_NZ: brTaken = ~fZ;
      OP_BR_NC: brTaken = ~fC;
      OP_BR_C:  brTaken = fC;
      default:  brTaken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accA <= 8'h00; idxX <= 8'h00; idxY <= 8'h00; sp <= SP_INIT;
      lo <= 8'h00; hi <= 8'h00; pc <= 16'h0000;
      fN <= 1'b0; fV <= 1'b0; fZ <= 1'b0; fC <= 1'b0;
    end else begin
      if (strb.exec) begin
        accA <= aNext; idxX <= xNext; idxY <= yNext;
        fC <= cNext;   fV <= vNext;
        if (nzUpd) begin fN <= nzVal[7]; fZ <= (nzVal == 8'h00); end
      end
      if (strb.exec)        sp <= spExec;
      else if (strb.spUp)   sp <= sp + 8'd1;
      else if (strb.spDown) sp <= sp - 8'd1;
      if (strb.loadLo) lo <= memRdata;
      if (strb.loadHi) hi <= memRdata;
      case (strb.pcSel)
        P_INC:     pc <= pc + 16'd1;
        P_LOAD_RD: pc <= {memRdata, lo};
        P_LOAD_HL: pc <= {hi, lo};
        P_BRANCH:  if (brTaken) pc <= pc + {{8{memRdata[7]}}, memRdata};
        P_RETURN:  pc <= {memRdata, lo} + 16'd1;
        default: ;
      endcase
    end
  end

  assign regA  = accA;
  assign regX  = idxX;
  assign regY  = idxY;
  assign regSp = sp;
  assign regPc = pc;
  assign flags = {fN, fV, fZ, fC};

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter logic [15:0] VEC_ADDR   = 16'hFFFC,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memWe,
  input  logic [7:0]  memRdata,
  output logic        opFetch,
  output logic        halted,
  output logic [7:0]  trapOpcode,
  output logic [15:0] trapPc,
  output logic [7:0]  regA,
  output logic [7:0]  regX,
  output logic [7:0]  regY,
  output logic [7:0]  regSp,
  output logic [15:0] regPc,
  output logic [3:0]  flags
);

  strobe_t    strb;
  logic [7:0] curOp;

  tiny8_ctrl u_ctrl (
    .clk(clk), .rst(rst), .memRdata(memRdata), .strb(strb), .curOp(curOp),
    .opFetch(opFetch), .halted(halted), .trapOpcode(trapOpcode)
  );

  tiny8_dpath #(.VEC_ADDR(VEC_ADDR), .STACK_PAGE(STACK_PAGE), .SP_INIT(SP_INIT)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .curOp(curOp), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .regA(regA), .regX(regX), .regY(regY), .regSp(regSp), .regPc(regPc), .flags(flags)
  );

  // The fetch step has already moved the PC past the trapping opcode.
  assign trapPc = halted ? (regPc - 16'd1) : 16'h0000;

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        memWe,
  input logic        opFetch,
  input logic        halted,
  input logic [7:0]  trapOpcode,
  input logic [15:0] trapPc,
  input logic [15:0] regPc
);

  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
    opFetch |=> !opFetch);

  assert_fetch_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    opFetch |-> !memWe);

  assert_trap_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(trapPc) && $stable(trapOpcode)));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !memWe);

  assert_halt_pc_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(regPc));

endmodule

bind tiny8_core tiny8_core_chk u_chk (.*);

// File: tb/tiny8_core_bench.sv
`timescale 1ns/1ps
module tiny8_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;
  logic        opFetch, halted;
  logic [7:0]  trapOpcode;
  logic [15:0] trapPc;
  logic [7:0]  regA, regX, regY, regSp;
  logic [15:0] regPc;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int fetchCnt = 0;
  logic [7:0] mem [0:2047];

  always #4 clk = ~clk;

  tiny8_core u_tiny8_core (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .opFetch(opFetch), .halted(halted), .trapOpcode(trapOpcode),
    .trapPc(trapPc), .regA(regA), .regX(regX), .regY(regY), .regSp(regSp),
    .regPc(regPc), .flags(flags)
  );

  // 2 KiB memory, aliased over the whole address space.
  always @(posedge clk) begin
    if (memWe) mem[memAddr[10:0]] <= memWdata;
    memRdata <= mem[memAddr[10:0]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) fetchCnt <= 0;
    else if (opFetch) fetchCnt <= fetchCnt + 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic loadProg(input logic [15:0] base, input logic [7:0] b[$]);
    foreach (b[i]) mem[base[10:0] + 11'(i)] <= b[i];
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    mem[a[10:0]] <= d;
  endtask

  // Holds reset, clears memory and sets the start vector to 0xF200.
  task automatic startReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
    poke(16'hFFFC, 8'h00);
    poke(16'hFFFD, 8'hF2);
  endtask

  task automatic releaseAndRun();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 8000 && !halted; n++) @(negedge clk);
    chk("run ends halted", {31'd0, halted}, 32'd1);
  endtask

  task automatic testReset();
    startReset();
    loadProg(16'hF200, {8'hEA, 8'hFF});
    @(negedge clk); @(negedge clk);
    chk("R1 A in reset", {24'd0, regA}, 32'h00);
    chk("R1 X,Y in reset", {16'd0, regX, regY}, 32'h0000);
    chk("R1 SP in reset", {24'd0, regSp}, 32'hFF);
    chk("R1 flags/we in reset", {27'd0, flags, memWe}, 32'd0);
    rst = 1'b0;
    #1 chk("R1 first vector address", {16'd0, memAddr}, 32'hFFFC);
    @(negedge clk); #1 chk("R1 second vector address", {16'd0, memAddr}, 32'hFFFD);
    @(negedge clk);
    @(negedge clk); #1 chk("R1 first fetch address", {15'd0, opFetch, memAddr}, {15'd0, 1'b1, 16'hF200});
    chk("R2 fetch not with write", {31'd0, memWe}, 32'd0);
    @(negedge clk); #1 chk("R2 fetch lasts one cycle", {31'd0, opFetch}, 32'd0);
  endtask

  task automatic testLoadStore();
    startReset();
    poke(16'h0010, 8'h7F); poke(16'h0011, 8'h05); poke(16'h0012, 8'hFF);
    loadProg(16'hF200, {8'hA5, 8'h10, 8'hA4, 8'h11, 8'hCA, 8'h86, 8'h20,
                        8'h8E, 8'h34, 8'h03, 8'hC8, 8'hC8, 8'h88, 8'hE6, 8'h10,
                        8'hE6, 8'h12, 8'hEA, 8'hA9, 8'h00, 8'hFF});
    releaseAndRun();
    chk("R3 A after load", {24'd0, regA}, 32'h00);
    chk("R3 X after decrement", {24'd0, regX}, 32'hFF);
    chk("R3 Y after steps", {24'd0, regY}, 32'h06);
    chk("R3 zero-page store", {24'd0, mem[11'h020]}, 32'hFF);
    chk("R3 absolute store", {24'd0, mem[11'h334]}, 32'hFF);
    chk("R3 memory increment", {24'd0, mem[11'h010]}, 32'h80);
    chk("R3 memory increment wrap", {24'd0, mem[11'h012]}, 32'h00);
    chk("R3 flags after load zero", {28'd0, flags}, 32'b0010);
    chk("R9 trap address", {16'd0, trapPc}, 32'hF214);
  endtask

  task automatic runFlags(input string what, input logic [7:0] b[$],
                          input logic [7:0] expA, input logic [3:0] expF);
    startReset();
    loadProg(16'hF200, b);
    releaseAndRun();
    chk({what, " A"}, {24'd0, regA}, {24'd0, expA});
    chk({what, " flags"}, {28'd0, flags}, {28'd0, expF});
  endtask

  task automatic testSubtract();
    runFlags("R4 borrow+overflow", {8'hE0, 8'h00, 8'hA9, 8'h50, 8'hE9, 8'hB0, 8'hFF}, 8'hA0, 4'b1100);
    runFlags("R4 borrow-in no borrow-out", {8'hE0, 8'h01, 8'hA9, 8'hA0, 8'hE9, 8'h00, 8'hFF}, 8'h9F, 4'b1001);
    runFlags("R4 zero result", {8'hE0, 8'h00, 8'hA9, 8'h42, 8'hE9, 8'h42, 8'hFF}, 8'h00, 4'b0011);
    runFlags("R4 negative to positive", {8'hE0, 8'h00, 8'hA9, 8'h80, 8'hE9, 8'h01, 8'hFF}, 8'h7F, 4'b0101);
  endtask

  task automatic testCompare();
    runFlags("R5 equal", {8'hCA, 8'hE0, 8'hFF, 8'hFF}, 8'h00, 4'b0011);
    chk("R5 X unchanged", {24'd0, regX}, 32'hFF);
    runFlags("R5 greater", {8'hCA, 8'hE0, 8'h80, 8'hFF}, 8'h00, 4'b0001);
    runFlags("R5 less", {8'hE0, 8'h01, 8'hFF}, 8'h00, 4'b1000);
  endtask

  task automatic testRotate();
    runFlags("R6 twice", {8'hE0, 8'h00, 8'hA9, 8'h81, 8'h2A, 8'h2A, 8'hFF}, 8'h07, 4'b0000);
    runFlags("R6 to zero", {8'hE0, 8'h01, 8'hA9, 8'h80, 8'h2A, 8'hFF}, 8'h00, 4'b0011);
  endtask

  task automatic testBranch();
    startReset();
    poke(16'h0030, 8'h03);
    loadProg(16'hF200, {8'hA4, 8'h30, 8'hE6, 8'h31, 8'h88, 8'hD0, 8'hFB,
                        8'hE0, 8'h01, 8'hB0, 8'h02, 8'h90, 8'h01, 8'hFF,
                        8'hE0, 8'h00, 8'hB0, 8'h01, 8'hFF, 8'hEA, 8'hFF});
    releaseAndRun();
    chk("R7 backward loop count", {24'd0, mem[11'h031]}, 32'h03);
    chk("R7 loop exit Y", {24'd0, regY}, 32'h00);
    chk("R7 forward branches land", {16'd0, trapPc}, 32'hF214);
  endtask

  task automatic testCall();
    startReset();
    loadProg(16'hF200, {8'hCA, 8'hCA, 8'h9A, 8'h20, 8'h10, 8'hF2, 8'hEA, 8'hFF});
    loadProg(16'hF210, {8'hC8, 8'h4C, 8'h20, 8'hF2, 8'hFF});
    loadProg(16'hF220, {8'h60});
    releaseAndRun();
    chk("R8 pushed high byte", {24'd0, mem[11'h1FE]}, 32'hF2);
    chk("R8 pushed low byte", {24'd0, mem[11'h1FD]}, 32'h05);
    chk("R8 SP after return", {24'd0, regSp}, 32'hFE);
    chk("R8 subroutine ran via jump", {24'd0, regY}, 32'h01);
    chk("R8 resumed after call", {16'd0, trapPc}, 32'hF207);
  endtask

  task automatic testDelayLoop();
    startReset();
    poke(16'h0040, 8'h10);
    loadProg(16'hF200, {8'hA9, 8'h01, 8'hE0, 8'h01, 8'hCA, 8'hE9, 8'h00,
                        8'hB0, 8'hF9, 8'hE6, 8'h40, 8'hFF});
    releaseAndRun();
    chk("R2 instruction count", fetchCnt, 32'd1031);
    chk("R4 loop A", {24'd0, regA}, 32'hFF);
    chk("R5 loop X", {24'd0, regX}, 32'hFF);
    chk("R3 counter incremented", {24'd0, mem[11'h040]}, 32'h11);
    chk("R4 loop final flags", {28'd0, flags}, 32'b0000);
  endtask

  task automatic testIllegal();
    int bad = 0;
    logic [15:0] pcHold;
    startReset();
    loadProg(16'hF200, {8'hEA, 8'hA2, 8'h05, 8'hCA});
    releaseAndRun();
    chk("R9 trap opcode", {24'd0, trapOpcode}, 32'hA2);
    chk("R9 trap address", {16'd0, trapPc}, 32'hF201);
    pcHold = regPc;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (memWe || !halted || regPc != pcHold) bad++;
    end
    chk("R10 frozen after halt", bad, 32'd0);
    chk("R10 operand not executed", {24'd0, regX}, 32'h00);
  endtask

  initial begin
    fork
      begin
        testReset();
        testLoadStore();
        testSubtract();
        testCompare();
        testRotate();
        testBranch();
        testCall();
        testDelayLoop();
        testIllegal();
      end
      begin
        wait (cycles >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule